// File: doc/BRIEF.md
# Latching PHY Status Register

This block holds the read-only basic status word of a 10/100 Ethernet PHY and a fixed identifier word, and returns either one on a management read port. The link, jabber and remote fault conditions arrive as live signals and are captured by latches. Link status is latch-low: a dropout is held until software reads the word. Jabber and remote fault are latch-high: an event is held until the next read. Each read of the status word returns the held values and then reloads every latch from its live input. A condition that is still present therefore shows up again on the next read.

Jabber is counted only in 10 Mb/s operation. Remote fault is taken from bit 13 of the link partner ability word. Autonegotiation complete is sampled directly when the read happens. The upper ability bits come from a constant parameter. Bits 6, 3 and 0 are fixed. The read data is registered and appears one cycle after the read strobe.

Top module: `phy_stat_regs`

## Requirements
- R1: While rst_ni is low, rdata_o is 0x0000 and the link, jabber and remote fault latches are 0. The first status read after reset therefore shows link 0, jabber 0 and remote fault 0.
- R2: A read of address 1 loads rdata_o at the clock edge where rd_i is high. The word has bit 0 = 1, bit 3 = 1 and bit 6 = 0, and bits 15..7 equal the ABILITY parameter (default 9'h0F0, giving 0x7809 with all status bits 0).
- R3: Bit 5 of the status word equals an_done_i as sampled at the read edge.
- R4: Bit 2 (link) reads 0 if link_up_i was 0 at any edge since the previous status read. This holds even if the link has since recovered.
- R5: Bit 1 (jabber) reads 1 if jabber_i was 1 while speed100_i was 0 at any edge since the previous status read. A jabber while speed100_i is 1 is ignored.
- R6: Bit 4 (remote fault) reads 1 if lp_ability_i[13] was 1 at any edge since the previous status read.
- R7: On a read of address 1, each latch reloads from its live input at that edge, so a persisting condition is reported again on the next read.
- R8: A read of address 2 returns ID_WORD (default 0x0181) and leaves all latches unchanged.
- R9: A read of any address other than 1 or 2 returns 0x0000 and leaves all latches unchanged.
- R10: rdata_o holds its value in cycles where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Live link-valid indication |
| jabber_i | input | 1 | Live jabber condition |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| an_done_i | input | 1 | Autonegotiation finished |
| lp_ability_i | input | 16 | Link partner ability word; bit 13 is remote fault |
| addr_i | input | 5 | Register address |
| rd_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 16 | Registered read data |

## Verification
A table of steps drives brief link dropouts followed by recovery. This shows latch-low holding apart from simply following the live link input. Jabber pulses are sent at both speeds, which separates speed gating from plain capture. Remote fault and autonegotiation complete are held across back-to-back reads to tell reload-on-read apart from clear-to-zero. Identifier reads, unmapped-address reads and an idle cycle confirm that the latches survive non-status reads and that the output holds when there is no strobe. A reset applied after jabber and remote fault events confirms that all three latches clear.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 16;
  localparam logic [AW-1:0] ADDR_STAT = 5'd1;
  localparam logic [AW-1:0] ADDR_ID   = 5'd2;
  // status word bit positions
  localparam int unsigned B_EXT   = 0;
  localparam int unsigned B_JAB   = 1;
  localparam int unsigned B_LINK  = 2;
  localparam int unsigned B_ANABL = 3;
  localparam int unsigned B_RFLT  = 4;
  localparam int unsigned B_ANDN  = 5;
  localparam int unsigned B_PRSUP = 6;
  localparam int unsigned B_ABL_LO = 7;
  localparam int unsigned ABL_W   = DW - B_ABL_LO;
  localparam int unsigned LP_RF_BIT = 13;
endpackage

// File: rtl/stat_latch.sv
module stat_latch #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic clr_i,
  output logic state_o
);
  localparam logic ACT = LATCH_HIGH;
  logic state_q, state_d;

  generate
    if (LATCH_HIGH) begin : g_hi
      always_comb state_d = clr_i ? live_i : (state_q | live_i);
    end else begin : g_lo
      always_comb state_d = clr_i ? live_i : (state_q & live_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= state_d;

  assign state_o = state_q;

  // event captured between reads (R4 low side, R5/R6 high side)
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && live_i == ACT) |=> state_o == ACT);
  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && state_o == ACT) |=> state_o == ACT);
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_o == $past(live_i));
endmodule

// File: rtl/phy_stat_rdmux.sv
module phy_stat_rdmux
  import phy_stat_pkg::*;
#(
  parameter logic [ABL_W-1:0] ABILITY = 9'h0F0,
  parameter logic [DW-1:0]    ID_WORD = 16'h0181
) (
  input  logic [AW-1:0] addr_i,
  input  logic          link_i,
  input  logic          jab_i,
  input  logic          rflt_i,
  input  logic          an_done_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] stat_w;

  always_comb begin
    stat_w = '0;
    stat_w[DW-1:B_ABL_LO] = ABILITY;
    stat_w[B_PRSUP] = 1'b0;
    stat_w[B_ANDN]  = an_done_i;
    stat_w[B_RFLT]  = rflt_i;
    stat_w[B_ANABL] = 1'b1;
    stat_w[B_LINK]  = link_i;
    stat_w[B_JAB]   = jab_i;
    stat_w[B_EXT]   = 1'b1;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT: word_o = stat_w;
      ADDR_ID:   word_o = ID_WORD;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
  import phy_stat_pkg::*;
#(
  parameter logic [ABL_W-1:0] ABILITY = 9'h0F0,
  parameter logic [DW-1:0]    ID_WORD = 16'h0181
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_up_i,
  input  logic          jabber_i,
  input  logic          speed100_i,
  input  logic          an_done_i,
  input  logic [DW-1:0] lp_ability_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o
);
  logic rd_stat;
  logic jab_live;
  logic link_q, jab_q, rflt_q;
  logic [DW-1:0] word;

  assign rd_stat  = rd_i && (addr_i == ADDR_STAT);
  assign jab_live = jabber_i & ~speed100_i;   // jabber counts only at 10 Mb/s

  stat_latch #(.LATCH_HIGH(1'b0)) u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(link_up_i), .clr_i(rd_stat), .state_o(link_q));
  stat_latch #(.LATCH_HIGH(1'b1)) u_jab (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(jab_live), .clr_i(rd_stat), .state_o(jab_q));
  stat_latch #(.LATCH_HIGH(1'b1)) u_rflt (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(lp_ability_i[LP_RF_BIT]), .clr_i(rd_stat),
    .state_o(rflt_q));

  phy_stat_rdmux #(.ABILITY(ABILITY), .ID_WORD(ID_WORD)) u_mux (
    .addr_i(addr_i), .link_i(link_q), .jab_i(jab_q), .rflt_i(rflt_q),
    .an_done_i(an_done_i), .word_o(word));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= word;

  p_consts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT) |=>
      (rdata_o[B_EXT] && rdata_o[B_ANABL] && !rdata_o[B_PRSUP] &&
       rdata_o[DW-1:B_ABL_LO] == ABILITY));
  p_andone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT) |=> rdata_o[B_ANDN] == $past(an_done_i));
  p_jab_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stat && !jab_q && speed100_i) |=> !jab_q);
  p_id_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_ID) |=> (rdata_o == ID_WORD && $stable(link_q) || $past(!link_q)));
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != ADDR_STAT && addr_i != ADDR_ID) |=> rdata_o == '0);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> rdata_o == '0);
endmodule

// File: tb/phy_stat_regs_tb.sv
module phy_stat_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link = 1'b1, jab = 1'b0, s100 = 1'b1, an = 1'b0;
  logic [15:0] lp = 16'h0;
  logic [4:0]  addr = 5'd0;
  logic        rd = 1'b0;
  logic [15:0] rdata;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  phy_stat_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link), .jabber_i(jab),
    .speed100_i(s100), .an_done_i(an), .lp_ability_i(lp),
    .addr_i(addr), .rd_i(rd), .rdata_o(rdata));

  // {rd, addr[4:0], link, jab, rf, an, s100, chk, exp[15:0]}
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 5'd0, 5'b10001, 1'b0, 16'h0000},
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h7809}, // R2 link latched low from reset
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h780D}, // R7 reload
    {1'b0, 5'd0, 5'b00001, 1'b0, 16'h0000},
    {1'b0, 5'd0, 5'b10001, 1'b0, 16'h0000},
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h7809}, // R4 dropout held
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h780D}, // R4
    {1'b0, 5'd0, 5'b11001, 1'b0, 16'h0000},
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h780D}, // R5 gated at 100
    {1'b0, 5'd0, 5'b11000, 1'b0, 16'h0000},
    {1'b0, 5'd0, 5'b10000, 1'b0, 16'h0000},
    {1'b1, 5'd2, 5'b10000, 1'b1, 16'h0181}, // R8
    {1'b1, 5'd7, 5'b10000, 1'b1, 16'h0000}, // R9
    {1'b1, 5'd1, 5'b10000, 1'b1, 16'h780F}, // R5 held through R8/R9
    {1'b1, 5'd1, 5'b10000, 1'b1, 16'h780D}, // R5
    {1'b0, 5'd0, 5'b10101, 1'b0, 16'h0000},
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h781D}, // R6
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h780D}, // R6
    {1'b1, 5'd1, 5'b10111, 1'b1, 16'h782D}, // R3
    {1'b1, 5'd1, 5'b10111, 1'b1, 16'h783D}, // R7 persisting fault
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h781D}, // R7
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h780D}, // R7
    {1'b0, 5'd0, 5'b00001, 1'b1, 16'h780D}, // R10 hold
    {1'b1, 5'd1, 5'b10001, 1'b1, 16'h7809}  // R10 then R4
  };

  function automatic string tag_of(int i);
    case (i)
      1: return "R2";  2: return "R7";  5, 6: return "R4";
      8, 13, 14: return "R5";  11: return "R8";  12: return "R9";
      16, 17: return "R6";  18: return "R3";  19, 20, 21: return "R7";
      22: return "R10";  default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata_o=%h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rdata, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {rd, addr, link, jab, lp[13], an, s100} = VEC[i][27:17];
      @(negedge clk);
      if (VEC[i][16]) check(tag_of(i), rdata, VEC[i][15:0]);
    end
    // R1: reset after jabber and remote fault events
    {rd, link, jab, lp[13], an, s100} = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    @(negedge clk);
    {jab, lp[13]} = 2'b00;
    rst_n = 1'b0;
    #1 check("R1", rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    {rd, addr, s100} = {1'b1, 5'd1, 1'b1};
    @(negedge clk);
    check("R1", rdata, 16'h7809);
    rd = 1'b0;
    // R9 corner: highest address
    {rd, addr} = {1'b1, 5'd31};
    @(negedge clk);
    check("R9", rdata, 16'h0000);
    {rd, addr} = {1'b1, 5'd1};
    @(negedge clk);
    check("R9", rdata, 16'h780D);
    rd = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule